// File: doc/BRIEF.md
# Atomic 16-bit Register Access Bridge

This block sits between an 8-bit processor bus and a bank of 16-bit peripheral registers, such as a counter, two compare values and a capture value. The processor moves each 16-bit value as two byte transfers. A single holding byte, shared by every register in the bank, makes sure the two halves belong together. The peripheral keeps ownership of its registers. The bridge only reads their live values and issues full-width write pulses.

Each register takes two consecutive byte addresses. The even address is the low byte and the odd address is the high byte; register `i` lives at addresses `2i` and `2i+1`.

For a write, software writes the high byte first, which only fills the holding byte. It then writes the low byte, which commits holding byte and low byte together as one 16-bit word. For a read, software reads the low byte first. That returns the live low byte and, at the same clock edge, captures the live high byte into the holding byte. The following high-byte read returns that captured byte. Because the holding byte is shared, interleaving accesses to two different registers mixes their halves. The bridge does nothing to prevent this.

Top module: `abr_bridge`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `rd_data`, `wr_stb`, `wr_data` and the holding byte are all zero.
- R2: A write to an odd in-range address loads `bus_wdata` into the holding byte at that edge. No write strobe follows.
- R3: A write to even address `2i` (in range) raises only `wr_stb[i]` for exactly the next cycle. In that cycle `wr_data` carries the holding byte in bits 15:8 and the written byte in bits 7:0.
- R4: A read of even address `2i` (in range) returns bits 7:0 of live register `i` on `rd_data` in the next cycle. At the same edge it copies bits 15:8 of that register into the holding byte.
- R5: A read of an odd in-range address returns the holding byte on `rd_data` in the next cycle and leaves the holding byte unchanged.
- R6: The holding byte is shared across all registers. A high-byte write to register `j` followed by a low-byte write to register `i` commits the byte written for `j` as the upper half of `i`.
- R7: An address whose slot (address shifted right by one) is `NUM_REGS` or above is outside the bank. Writing there raises no strobe and leaves the holding byte unchanged. Reading there returns zero.
- R8: When `bus_wr` and `bus_rd` are high together, only the write is performed. `rd_data` keeps its previous value whenever no read is performed.
- R9: At most one bit of `wr_stb` is high in any cycle. A low-byte write does not change the holding byte, and `wr_data` holds its value between commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; bit 0 selects the high byte |
| bus_wdata | input | 8 | Write data byte |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| live_regs | input | 16*NUM_REGS | Current register values; register i in bits 16i+15:16i |
| rd_data | output | 8 | Read data, valid the cycle after a read |
| wr_stb | output | NUM_REGS | One-cycle commit pulse per register |
| wr_data | output | 16 | Word committed with the strobe |

## Verification
The hardest situation to reach from the ports is the shared holding byte being corrupted by interleaved traffic. The stimulus produces it deliberately. It writes a high byte for one register and a high byte for another, then a low byte for the first, and checks that the later high byte lands in the committed word. It also places a low-byte read of one register between a high-byte write and the low-byte write of another, so the captured high byte replaces the written one. Live register values change between a low read and its high read, to show that the high byte comes from the earlier capture. A long stretch of random mixed reads and writes, including simultaneous strobes and out-of-bank addresses, is then compared cycle by cycle against the reference model.

// File: rtl/abr_pkg.sv
package abr_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    // Kind of bus access in the current cycle, after priority and range checks.
    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_WR_HI,
        ACC_WR_LO,
        ACC_RD_HI,
        ACC_RD_LO,
        ACC_RD_MISS
    } acc_e;

endpackage

// File: rtl/abr_decode.sv
module abr_decode
    import abr_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int NUM_REGS = 4,
    parameter int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output acc_e              acc,
    output logic [IDX_W-1:0]  idx
);
    localparam int SLOT_W = ADDR_W - 1;
    localparam logic [SLOT_W-1:0] SLOT_LIMIT = SLOT_W'(NUM_REGS);

    logic [SLOT_W-1:0] slot;
    logic              hit;

    always_comb begin
        slot = addr[ADDR_W-1:1];
        hit  = (slot < SLOT_LIMIT);
        idx  = slot[IDX_W-1:0];
        acc  = ACC_IDLE;
        // A write wins over a simultaneous read.
        if (wr) begin
            if (hit) acc = addr[0] ? ACC_WR_HI : ACC_WR_LO;
        end else if (rd) begin
            if (!hit)        acc = ACC_RD_MISS;
            else if (addr[0]) acc = ACC_RD_HI;
            else              acc = ACC_RD_LO;
        end
    end

endmodule

// File: rtl/abr_read_mux.sv
module abr_read_mux
    import abr_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic [NUM_REGS*WORD_W-1:0] live_regs,
    input  logic [IDX_W-1:0]           idx,
    output logic [BYTE_W-1:0]          lo_byte,
    output logic [BYTE_W-1:0]          hi_byte
);
    logic [WORD_W-1:0] words [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_unpack
        assign words[g] = live_regs[g*WORD_W +: WORD_W];
    end

    logic [WORD_W-1:0] picked;

    always_comb begin
        picked = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (IDX_W'(k) == idx) picked = words[k];
        end
        lo_byte = picked[BYTE_W-1:0];
        hi_byte = picked[WORD_W-1:BYTE_W];
    end

endmodule

// File: rtl/abr_bridge.sv
module abr_bridge
    import abr_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int NUM_REGS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [7:0]                 bus_wdata,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [NUM_REGS*16-1:0]     live_regs,
    output logic [7:0]                 rd_data,
    output logic [NUM_REGS-1:0]        wr_stb,
    output logic [15:0]                wr_data
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    typedef struct packed {
        logic [BYTE_W-1:0]   temp;
        logic [BYTE_W-1:0]   rdata;
        logic [NUM_REGS-1:0] stb;
        logic [WORD_W-1:0]   wdata;
    } state_t;

    state_t d, q;

    acc_e              acc;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] live_lo;
    logic [BYTE_W-1:0] live_hi;

    abr_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_decode (
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .acc  (acc),
        .idx  (idx)
    );

    abr_read_mux #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_mux (
        .live_regs (live_regs),
        .idx       (idx),
        .lo_byte   (live_lo),
        .hi_byte   (live_hi)
    );

    always_comb begin
        d     = q;
        d.stb = '0;
        unique case (acc)
            ACC_WR_HI: d.temp = bus_wdata;
            ACC_WR_LO: begin
                d.stb[idx] = 1'b1;
                d.wdata    = {q.temp, bus_wdata};
            end
            ACC_RD_LO: begin
                d.rdata = live_lo;
                d.temp  = live_hi;
            end
            ACC_RD_HI:   d.rdata = q.temp;
            ACC_RD_MISS: d.rdata = '0;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_data = q.rdata;
    assign wr_stb  = q.stb;
    assign wr_data = q.wdata;

endmodule

// File: rtl/abr_checker.sv
module abr_checker #(
    parameter int ADDR_W   = 4,
    parameter int NUM_REGS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [7:0]             bus_wdata,
    input logic                   bus_wr,
    input logic                   bus_rd,
    input logic [NUM_REGS*16-1:0] live_regs,
    input logic [7:0]             rd_data,
    input logic [NUM_REGS-1:0]    wr_stb,
    input logic [15:0]            wr_data,
    input logic [7:0]             temp_byte
);
    logic [ADDR_W-2:0] slot;
    logic              in_bank;
    logic [15:0]       sel_word;

    always_comb begin
        slot     = bus_addr[ADDR_W-1:1];
        in_bank  = (32'(slot) < NUM_REGS);
        sel_word = 16'(live_regs >> (32'(slot) * 16));
    end

    assert_strobe_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb));

    assert_strobe_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_stb) |-> $past(bus_wr && !bus_addr[0]));

    assert_strobe_low_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_stb) |-> (wr_data[7:0] == $past(bus_wdata)));

    assert_hi_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[0] && in_bank) |=> (temp_byte == $past(bus_wdata)) && (wr_stb == '0));

    assert_miss_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !in_bank) |=> (wr_stb == '0) && $stable(temp_byte));

    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd || bus_wr) |=> $stable(rd_data));

    assert_low_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && !bus_addr[0] && in_bank)
        |=> (rd_data == $past(sel_word[7:0])) && (temp_byte == $past(sel_word[15:8])));

endmodule

bind abr_bridge abr_checker #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS)
) u_abr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .live_regs (live_regs),
    .rd_data   (rd_data),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .temp_byte (q.temp)
);

// File: tb/tb_abr_bridge.sv
`timescale 1ns/1ps
module tb_abr_bridge;
    localparam int ADDR_W   = 4;
    localparam int NUM_REGS = 4;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [ADDR_W-1:0]      bus_addr = '0;
    logic [7:0]             bus_wdata = '0;
    logic                   bus_wr = 1'b0;
    logic                   bus_rd = 1'b0;
    logic [NUM_REGS*16-1:0] live_regs;
    logic [7:0]             rd_data;
    logic [NUM_REGS-1:0]    wr_stb;
    logic [15:0]            wr_data;

    logic [15:0] live_m [NUM_REGS];

    always_comb begin
        for (int k = 0; k < NUM_REGS; k++) live_regs[k*16 +: 16] = live_m[k];
    end

    always #2 clk = ~clk;

    abr_bridge #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) dut (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_wr (bus_wr), .bus_rd (bus_rd), .live_regs (live_regs),
        .rd_data (rd_data), .wr_stb (wr_stb), .wr_data (wr_data)
    );

    // Behavioural reference model
    int m_temp, m_rd, m_stb, m_wdata;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_temp = 0; m_rd = 0; m_stb = 0; m_wdata = 0;
        end else begin
            int slot;
            slot  = int'(bus_addr) / 2;
            m_stb = 0;
            if (bus_wr) begin
                if (slot < NUM_REGS) begin
                    if (bus_addr[0]) m_temp = bus_wdata;
                    else begin
                        m_stb   = 1 << slot;
                        m_wdata = m_temp * 256 + bus_wdata;
                    end
                end
            end else if (bus_rd) begin
                if (slot >= NUM_REGS) m_rd = 0;
                else if (bus_addr[0]) m_rd = m_temp;
                else begin
                    m_rd   = live_m[slot] % 256;
                    m_temp = live_m[slot] / 256;
                end
            end
        end
    end

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check(cur_req, "rd_data", int'(rd_data), m_rd);
        check(cur_req, "wr_stb",  int'(wr_stb),  m_stb);
        check(cur_req, "wr_data", int'(wr_data), m_wdata);
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic wr_op(int addr, int data);
        bus_addr = ADDR_W'(addr); bus_wdata = 8'(data); bus_wr = 1'b1; bus_rd = 1'b0;
        tick();
        idle();
    endtask

    task automatic rd_op(int addr);
        bus_addr = ADDR_W'(addr); bus_rd = 1'b1; bus_wr = 1'b0;
        tick();
        idle();
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        live_m[0] = 16'h1111; live_m[1] = 16'h2222;
        live_m[2] = 16'hABCD; live_m[3] = 16'h4455;
        repeat (3) @(negedge clk);
        cur_req = "R1";                  // reset values
        compare_all();
        rst_n = 1'b1;
        tick();
        compare_all();

        cur_req = "R2";                  // high byte only loads the holding byte
        wr_op(1, 8'h12);
        tick();
        cur_req = "R3";                  // low byte commits the word
        wr_op(0, 8'h34);
        check("R3", "committed word", int'(wr_data), 16'h1234);
        check("R3", "strobe reg0", int'(wr_stb), 1);
        tick();
        check("R3", "strobe one cycle", int'(wr_stb), 0);
        cur_req = "R9";                  // low write leaves holding byte
        rd_op(1);
        check("R9", "holding after low write", int'(rd_data), 8'h12);

        cur_req = "R4";                  // low read captures high byte
        rd_op(4);
        check("R4", "low byte of reg2", int'(rd_data), 8'hCD);
        live_m[2] = 16'h9988;
        tick();
        cur_req = "R5";                  // high read returns the capture
        rd_op(5);
        check("R5", "captured high byte", int'(rd_data), 8'hAB);
        rd_op(5);
        check("R5", "holding byte unchanged", int'(rd_data), 8'hAB);

        cur_req = "R6";                  // interleaving corrupts the holding byte
        wr_op(3, 8'h55);
        wr_op(7, 8'h66);
        wr_op(2, 8'h77);
        check("R6", "mixed word into reg1", int'(wr_data), 16'h6677);
        check("R6", "strobe reg1", int'(wr_stb), 2);
        wr_op(5, 8'hEE);
        rd_op(6);
        wr_op(0, 8'h01);
        check("R6", "captured byte replaces written", int'(wr_data), 16'h4401);

        cur_req = "R7";                  // out-of-bank addresses
        wr_op(9, 8'hF0);
        wr_op(8, 8'hF1);
        check("R7", "no strobe out of bank", int'(wr_stb), 0);
        rd_op(1);
        check("R7", "holding byte untouched", int'(rd_data), 8'h44);
        rd_op(12);
        check("R7", "miss read returns zero", int'(rd_data), 0);

        cur_req = "R8";                  // write wins, rd_data holds
        rd_op(0);
        bus_addr = 4'd2; bus_wdata = 8'h3C; bus_wr = 1'b1; bus_rd = 1'b1;
        tick();
        idle();
        check("R8", "rd_data held on joint access", int'(rd_data), 8'h11);
        check("R8", "write performed", int'(wr_stb), 2);
        tick(); tick();
        check("R8", "rd_data held while idle", int'(rd_data), 8'h11);

        cur_req = "R9";                  // random traffic against the model
        for (int n = 0; n < 600; n++) begin
            if (n % 50 == 0) live_m[n / 50 % NUM_REGS] = 16'($urandom);
            bus_addr  = ADDR_W'($urandom);
            bus_wdata = 8'($urandom);
            bus_wr    = ($urandom % 3) == 0;
            bus_rd    = ($urandom % 2) == 0;
            tick();
        end
        idle();
        tick();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule